// File: doc/BRIEF.md
# Memory Fill-and-Verify Tester

This block is a hardware sequencer that exercises every storage bit of a RAM region through a simple synchronous memory port. A start pulse takes in a base address and a word count. The tester then writes a unique, incrementing value to each word of the region. Only after the whole region has been written does it read every word back. On each word that checks correctly, it writes the bitwise inverse of that value. A third sweep reads the inverses back and clears each word that checks correctly. Each bit is therefore seen both as 0 and as 1.

The memory port carries a request, a write enable, an address and write data. Read data arrives registered on the cycle after a read request, and there is never more than one read in flight. Every read of the region is issued after the last write of the fill sweep. If no device answers and the bus only holds the charge of the last write, the first read returns a stale value and the test fails. An immediate write-then-read check would have missed that fault. The first mismatch ends the run and reports the address of that word. A clean run reports pass with a zero failure address and leaves the region cleared.

Top module: `mem_fill_verify`

## Requirements
- R1: The fill sweep writes word i of the region (i = 0 .. count-1) in ascending order, one write per cycle, with the value (i+1) modulo 2^DATA_W. The first word gets 1, and word 255 of an 8-bit memory gets 0.
- R2: No read is issued until the fill sweep has written every word of the region. At most one read is in flight: a read request is never followed by another read request in the next cycle.
- R3: The verify sweep reads word i and compares it with (i+1) modulo 2^DATA_W. On a match it writes the bitwise inverse of that value to the same address, in the cycle the read data is returned. Only then does it move to the next word.
- R4: The final sweep reads word i and compares it with the inverse of (i+1). On a match it writes zero to that address before it moves on.
- R5: On the first mismatch the tester stops. It makes no further memory access, writes nothing to the failing word, and signals done with pass low and failAddr equal to that word's address.
- R6: A run with no mismatch signals done with pass high and failAddr zero, and leaves every word of the region holding zero.
- R7: A word count of zero makes no memory access and signals done with pass high on the second clock edge after the start is accepted.
- R8: busy is high from the first edge after an accepted start until the run ends. done is a single-cycle pulse, and busy is low while done is high.
- R9: start is accepted only while both busy and done are low. A start pulse during a run has no effect on that run.
- R10: After reset, busy, done, pass, memReq, memWe and failAddr are all low.
- R11: pass and failAddr keep their values from the end of a run until the next accepted start.
- R12: Word addresses are base + i modulo 2^ADDR_W, so a region may wrap past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| baseAddr | input | ADDR_W | First word address of the region |
| wordCount | input | ADDR_W+1 | Number of words in the region |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run found no mismatch |
| failAddr | output | ADDR_W | Address of the first mismatch, zero on pass |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
The hardest situations to reach from the ports are a failure found only in the final sweep and a device that is absent while the bus still echoes its last write. The bench memory model can replace read data with the last value driven on the bus, which models the absent device. It can also force chosen bits of one word high or low on reads. A bit stuck high passes the first compare and fails only against the inverse, so it exercises the third sweep. Around each such failure, the bench inspects the model's contents to confirm which words were already inverted or cleared and which were left alone.

// File: rtl/mfv_pkg.sv
package mfv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD1,
    ST_CK1,
    ST_RD2,
    ST_CK2,
    ST_FIN
  } mfvState_e;

  typedef enum logic [1:0] {
    WD_PAT,
    WD_INV,
    WD_ZERO
  } wdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;     // capture base/count, clear result
    logic   clrIdx;   // restart word index and pattern
    logic   incIdx;   // advance word index and pattern
    logic   setPass;  // record success
    logic   setFail;  // record current address as failing
    wdSel_e wdSel;    // write data source
  } mfvStrobe_t;

endpackage

// File: rtl/mfv_dpath.sv
module mfv_dpath
  import mfv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfvStrobe_t        strb,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              countZero,
  output logic              lastWord,
  output logic              matchPat,
  output logic              matchInv,
  output logic              pass,
  output logic [ADDR_W-1:0] failAddr
);

  localparam logic [DATA_W-1:0] PAT_FIRST = DATA_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  idxQ;
  logic [DATA_W-1:0] patQ;
  logic              passQ;
  logic [ADDR_W-1:0] failQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (strb.load) begin
      baseQ <= baseIn;
      cntQ  <= countIn;
    end
  end

  // word index and the regenerated incrementing pattern move together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      patQ <= PAT_FIRST;
    end else if (strb.load || strb.clrIdx) begin
      idxQ <= '0;
      patQ <= PAT_FIRST;
    end else if (strb.incIdx) begin
      idxQ <= idxQ + CNT_ONE;
      patQ <= patQ + PAT_FIRST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passQ <= 1'b0;
      failQ <= '0;
    end else if (strb.load) begin
      passQ <= 1'b0;
      failQ <= '0;
    end else if (strb.setFail) begin
      passQ <= 1'b0;
      failQ <= memAddr;
    end else if (strb.setPass) begin
      passQ <= 1'b1;
      failQ <= '0;
    end
  end

  assign memAddr   = baseQ + idxQ[ADDR_W-1:0];
  assign countZero = (cntQ == '0);
  assign lastWord  = (idxQ == (cntQ - CNT_ONE));
  assign matchPat  = (memRdata == patQ);
  assign matchInv  = (memRdata == ~patQ);

  always_comb begin
    case (strb.wdSel)
      WD_PAT:  memWdata = patQ;
      WD_INV:  memWdata = ~patQ;
      default: memWdata = '0;
    endcase
  end

  assign pass     = passQ;
  assign failAddr = failQ;

endmodule

// File: rtl/mfv_ctrl.sv
module mfv_ctrl
  import mfv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       countZero,
  input  logic       lastWord,
  input  logic       matchPat,
  input  logic       matchInv,
  output mfvStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);

  mfvState_e stQ, stNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNxt;
  end

  always_comb begin
    stNxt  = stQ;
    strb   = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stNxt     = ST_FILL;
        end
      end
      ST_FILL: begin
        if (countZero) begin
          strb.setPass = 1'b1;
          stNxt        = ST_FIN;
        end else begin
          memReq     = 1'b1;
          memWe      = 1'b1;
          strb.wdSel = WD_PAT;
          if (lastWord) begin
            strb.clrIdx = 1'b1;
            stNxt       = ST_RD1;
          end else begin
            strb.incIdx = 1'b1;
          end
        end
      end
      ST_RD1: begin
        memReq = 1'b1;
        stNxt  = ST_CK1;
      end
      ST_CK1: begin
        if (matchPat) begin
          memReq     = 1'b1;
          memWe      = 1'b1;
          strb.wdSel = WD_INV;
          if (lastWord) begin
            strb.clrIdx = 1'b1;
            stNxt       = ST_RD2;
          end else begin
            strb.incIdx = 1'b1;
            stNxt       = ST_RD1;
          end
        end else begin
          strb.setFail = 1'b1;
          stNxt        = ST_FIN;
        end
      end
      ST_RD2: begin
        memReq = 1'b1;
        stNxt  = ST_CK2;
      end
      ST_CK2: begin
        if (matchInv) begin
          memReq     = 1'b1;
          memWe      = 1'b1;
          strb.wdSel = WD_ZERO;
          if (lastWord) begin
            strb.setPass = 1'b1;
            stNxt        = ST_FIN;
          end else begin
            strb.incIdx = 1'b1;
            stNxt       = ST_RD2;
          end
        end else begin
          strb.setFail = 1'b1;
          stNxt        = ST_FIN;
        end
      end
      ST_FIN:  stNxt = ST_IDLE;
      default: stNxt = ST_IDLE;
    endcase
  end

  assign busy = (stQ != ST_IDLE) && (stQ != ST_FIN);
  assign done = (stQ == ST_FIN);

endmodule

// File: rtl/mem_fill_verify.sv
module mem_fill_verify
  import mfv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] failAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  mfvStrobe_t strb;
  logic countZero, lastWord, matchPat, matchInv;

  mfv_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .countZero (countZero),
    .lastWord  (lastWord),
    .matchPat  (matchPat),
    .matchInv  (matchInv),
    .strb      (strb),
    .memReq    (memReq),
    .memWe     (memWe),
    .busy      (busy),
    .done      (done)
  );

  mfv_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseIn    (baseAddr),
    .countIn   (wordCount),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .countZero (countZero),
    .lastWord  (lastWord),
    .matchPat  (matchPat),
    .matchInv  (matchInv),
    .pass      (pass),
    .failAddr  (failAddr)
  );

endmodule

// File: rtl/mfv_chk.sv
module mfv_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [CNT_W-1:0]  wordCount,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] failAddr,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  logic              idle;
  logic              rdReq;
  logic [ADDR_W-1:0] baseL;
  logic [CNT_W-1:0]  cntL;
  logic [ADDR_W-1:0] offs;

  assign idle  = !busy && !done;
  assign rdReq = memReq && !memWe;
  assign offs  = memAddr - baseL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseL <= '0;
      cntL  <= '0;
    end else if (start && idle) begin
      baseL <= baseAddr;
      cntL  <= wordCount;
    end
  end

  // R2: one read in flight
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R5: nothing touches memory at the end of a run
  a_r5_quiet_at_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R6: pass reports a null address
  a_r6_pass_null: assert property (@(posedge clk) disable iff (!rstN)
    (done && pass) |-> (failAddr == '0));

  // R7: empty region finishes at once with pass
  a_r7_empty_region: assert property (@(posedge clk) disable iff (!rstN)
    (start && idle && (wordCount == '0)) |=> !memReq ##1 (done && pass));

  // R8: done is a pulse and excludes busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R11: results hold while idle
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(pass) && $stable(failAddr)));

  // R12: every access lands inside the (wrapping) region
  a_r12_addr_window: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ({1'b0, offs} < cntL));

endmodule

bind mem_fill_verify mfv_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (ADDR_W + 1)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .baseAddr  (baseAddr),
  .wordCount (wordCount),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .failAddr  (failAddr),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr)
);

// File: tb/sim_mem_fill_verify.sv
module sim_mem_fill_verify;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [CW-1:0] wordCount = '0;
  logic          busy, done, pass, memReq, memWe;
  logic [AW-1:0] failAddr, memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  mem_fill_verify #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .wordCount(wordCount), .busy(busy), .done(done), .pass(pass),
    .failAddr(failAddr), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model with fault injection ----------------
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] busLast = '0;
  int            faultMode = 0;  // 0 none, 1 absent device, 2 stuck bits, 3 address alias
  logic [AW-1:0] faultAt = '0;
  logic [DW-1:0] stk0 = '0, stk1 = '0;

  function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
    return (faultMode == 3) ? (a & ~AW'(8)) : a;
  endfunction

  function automatic logic [DW-1:0] rdVal(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    if (faultMode == 1) return busLast;
    v = mem[phys(a)];
    if (faultMode == 2 && a == faultAt) v = (v & ~stk0) | stk1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (memReq && memWe) begin
      busLast <= memWdata;
      if (faultMode != 1) mem[phys(memAddr)] <= memWdata;
    end
    if (memReq && !memWe) memRdata <= rdVal(memAddr);
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } txn_t;

  txn_t q[$];
  bit   sbOn = 1'b0;
  int   accCnt = 0;
  int   firstRd = -1;

  // driver side: expected access stream of a clean run
  task automatic pushExpected(input logic [AW-1:0] b, input int n);
    for (int i = 0; i < n; i++) q.push_back('{1'b1, AW'(b + i), DW'(i + 1)});
    for (int i = 0; i < n; i++) begin
      q.push_back('{1'b0, AW'(b + i), '0});
      q.push_back('{1'b1, AW'(b + i), ~DW'(i + 1)});
    end
    for (int i = 0; i < n; i++) begin
      q.push_back('{1'b0, AW'(b + i), '0});
      q.push_back('{1'b1, AW'(b + i), '0});
    end
  endtask

  // monitor side
  always @(negedge clk) begin
    if (memReq) begin
      if (!memWe && firstRd < 0) firstRd = accCnt;
      accCnt++;
      if (sbOn) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "unexpected access", memAddr, 0);
        end else begin
          txn_t e;
          e = q.pop_front();
          check(memWe == e.we, "R2", "access kind", memWe, e.we);
          check(memAddr == e.a, "R12", "access address", memAddr, e.a);
          if (e.we) check(memWdata == e.d, "R3", "write data", memWdata, e.d);
        end
      end
    end
  end

  // ---------------- run helpers ----------------
  int waited;

  task automatic kick(input logic [AW-1:0] b, input int n);
    @(negedge clk);
    baseAddr  = b;
    wordCount = CW'(n);
    start     = 1'b1;
    accCnt    = 0;
    firstRd   = -1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
  endtask

  task automatic waitDone();
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R8", "done reached", done, 1);
    check(busy == 1'b0, "R8", "busy low with done", busy, 0);
  endtask

  task automatic afterDone();
    @(negedge clk);
    check(done == 1'b0, "R8", "done is one cycle", done, 0);
  endtask

  task automatic cleanRun(input logic [AW-1:0] b, input int n, input string req);
    int nz;
    faultMode = 0;
    pushExpected(b, n);
    sbOn = 1'b1;
    kick(b, n);
    waitDone();
    check(pass == 1'b1, req, "pass", pass, 1);
    check(failAddr == '0, "R6", "null fail address", failAddr, 0);
    afterDone();
    sbOn = 1'b0;
    check(q.size() == 0, "R4", "all expected accesses seen", q.size(), 0);
    q.delete();
    nz = 0;
    for (int i = 0; i < n; i++) if (mem[AW'(b + i)] != '0) nz++;
    check(nz == 0, "R6", "region cleared (nonzero words)", nz, 0);
  endtask

  task automatic failRun(input logic [AW-1:0] b, input int n,
                         input logic [AW-1:0] expFail, input string req);
    sbOn = 1'b0;
    kick(b, n);
    waitDone();
    check(pass == 1'b0, req, "pass low on mismatch", pass, 0);
    check(failAddr == expFail, req, "fail address", failAddr, expFail);
    afterDone();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    repeat (3) @(negedge clk);
    check({busy, done, pass, memReq, memWe} == 5'b0, "R10", "reset outputs",
          {busy, done, pass, memReq, memWe}, 0);
    check(failAddr == '0, "R10", "reset fail address", failAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: empty region
    kick(AW'(5), 0);
    waitDone();
    check(waited == 1, "R7", "cycles to done", waited, 1);
    check(pass == 1'b1, "R7", "empty region passes", pass, 1);
    check(accCnt == 0, "R7", "no accesses", accCnt, 0);
    afterDone();

    // R1/R3/R4: single word and small region
    cleanRun(AW'(16), 1, "R3");
    cleanRun(AW'(64), 12, "R4");

    // R12: region wrapping past the top of the address space
    cleanRun(AW'(DEPTH - 8), 20, "R12");

    // R1: pattern wraps at the data width
    cleanRun(AW'(0), 300, "R1");

    // R9: start pulse during a run is ignored
    faultMode = 0;
    pushExpected(AW'(128), 10);
    sbOn = 1'b1;
    kick(AW'(128), 10);
    repeat (3) @(negedge clk);
    baseAddr = AW'(512); wordCount = CW'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check(pass == 1'b1, "R9", "run unaffected by second start", pass, 1);
    afterDone();
    sbOn = 1'b0;
    check(q.size() == 0, "R9", "expected stream consumed", q.size(), 0);
    q.delete();

    // R2: absent device echoing the last bus value
    faultMode = 1;
    failRun(AW'(0), 16, AW'(0), "R2");
    check(firstRd == 16, "R2", "first read after all writes", firstRd, 16);
    check(accCnt == 17, "R5", "accesses before stop", accCnt, 17);

    // R5/R3: bit stuck low fails in the verify sweep
    faultMode = 2; faultAt = AW'(384 + 5); stk0 = DW'(2); stk1 = '0;
    failRun(AW'(384), 8, AW'(384 + 5), "R5");
    check(accCnt == 19, "R5", "accesses before stop", accCnt, 19);
    check(mem[384 + 4] == ~DW'(5), "R3", "previous word inverted", mem[384 + 4], ~DW'(5));
    check(mem[384 + 6] == DW'(7), "R5", "later word untouched", mem[384 + 6], DW'(7));
    repeat (5) @(negedge clk);
    check(failAddr == AW'(384 + 5) && !pass, "R11", "result held", failAddr, 384 + 5);

    // R4/R5: bit stuck high fails only against the inverse
    faultMode = 2; faultAt = AW'(256 + 2); stk0 = '0; stk1 = DW'(1);
    failRun(AW'(256), 8, AW'(256 + 2), "R4");
    check(mem[256] == '0 && mem[257] == '0, "R4", "earlier words cleared",
          {mem[256], mem[257]}, 0);
    check(mem[258] == ~DW'(3), "R5", "failing word not written", mem[258], ~DW'(3));
    check(mem[259] == ~DW'(4), "R4", "later word still inverted", mem[259], ~DW'(4));

    // R5: aliased address line
    faultMode = 3;
    failRun(AW'(0), 16, AW'(0), "R5");

    // R6: pass after a failure clears the result
    cleanRun(AW'(700), 9, "R6");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule